// File: doc/BRIEF.md
# Third-Order Cascaded Integrator-Comb Decimator

This block reduces the sample rate of a stream of signed fixed-point samples by an integer factor `L` using a third-order cascaded integrator-comb structure. Every accepted input sample is first shifted right arithmetically by `D` bits. This pre-scaling keeps the gain of the full filter, `L^3 / 2^D`, at or below one. The scaled sample then runs through three running-sum stages at the input rate. On every `L`-th accepted sample, the last running sum is handed to three first-difference stages at the output rate. Their result is registered as the output word.

All internal registers are exactly as wide as the input word. The running sums are expected to overflow and wrap modulo `2^W`. Two's-complement arithmetic guarantees that the differences taken afterwards recover the true, in-range result. The output therefore uses the same signed format as the input.

A small controller tracks the decimation phase. It has two states:
- `PH_GATHER`: collecting the first `L-1` accepted samples of a group.
- `PH_TAP`: the next accepted sample completes the group.

It has two transitions:
- `GATHER_TO_TAP`: taken on the accepted sample that brings the in-group count to `L-1`.
- `TAP_TO_GATHER`: taken on the accepted sample that completes the group. That sample fires the comb chain.

With `L = 2`, the first accepted sample after entering `PH_GATHER` already takes `GATHER_TO_TAP`.

Top module: `cic_decimator`

## Requirements
- R1: A synchronous reset drives `out_valid` and `out_data` to 0 and clears all running sums, difference delays and the phase counter. After reset, the filter behaves as if every earlier input were zero, and the first group starts with the first accepted sample.
- R2: Each accepted sample `x` enters the filter as `floor(x / 2^D)`, an arithmetic right shift by `D` with sign extension. For example, with `D = 6`, an input of -1 enters as -1, 63 enters as 0 and 64 enters as 1.
- R3: `out_valid` is a single-cycle pulse. It rises in the cycle after the `k*L`-th accepted sample (counted from reset) and at no other time, so two pulses are never adjacent.
- R4: A cycle with `in_valid` low changes neither the filter state nor the decimation phase.
- R5: With `xs[n]` the scaled sample for accepted sample `n` (`n` counted from 0 after reset), the pulse after sample `n = kL-1` carries `sum h[j]*xs[n-j]`. Here `h` is the threefold convolution of a length-`L` run of ones, `xs` is 0 for negative indices, and the result is taken modulo `2^W` as a signed `W`-bit value.
- R6: The running sums wrap modulo `2^W` and never saturate. A long run of full-scale input still yields the correct in-range output after the sums have wrapped many times.
- R7: `out_data` holds its value in every cycle without a pulse.
- R8: For a constant input `c`, every pulse from the third one onward (once the response window is full) carries `L^3 * floor(c / 2^D)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the input and output rates |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` as a new input-rate sample |
| in_data | input | W | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle pulse marking a new decimated sample |
| out_data | output | W | Signed decimated sample, held between pulses |

## Verification
The bench drives full-scale positive and negative constants for thousands of samples. A design that saturated its running sums, or widened and then truncated them wrongly, would settle on a value other than `L^3` times the scaled constant. Inputs such as -1, 63 and 64 target the shift. A logical shift or a rounding shift would give a positive or off-by-one steady value. The bench also sweeps every input code with idle cycles mixed in, and a reset is applied part-way through a group. A counter that advanced on idle cycles, or kept its phase across reset, would pulse at the wrong sample and with the wrong sum.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Decimation phase of the controller.
    typedef enum logic [0:0] {
        PH_GATHER = 1'b0,
        PH_TAP    = 1'b1
    } phase_e;

endpackage

// File: rtl/cic_integ_stage.sv
module cic_integ_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum_nxt
);

    logic [W-1:0] acc_q;

    // Running sum, allowed to wrap modulo 2^W.
    assign sum_nxt = acc_q + din;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= sum_nxt;
        end
    end

endmodule

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] dly_q;

    // First difference at the decimated rate.
    assign dout = din - dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else if (en) begin
            dly_q <= din;
        end
    end

endmodule

// File: rtl/cic_decim_ctrl.sv
module cic_decim_ctrl
    import cic_pkg::*;
#(
    parameter int L = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic tap
);

    localparam int CW = $clog2(L) + 1;
    localparam logic [CW-1:0] LAST_GATHER = CW'(L - 2);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_GATHER;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_GATHER: begin
                if (in_valid) begin
                    if (cnt_q == LAST_GATHER) begin
                        state_d = PH_TAP;      // GATHER_TO_TAP
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_TAP: begin
                if (in_valid) begin
                    state_d = PH_GATHER;       // TAP_TO_GATHER
                end
            end
            default: begin
                state_d = PH_GATHER;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        tap = 1'b0;
        unique case (state_q)
            PH_GATHER: tap = 1'b0;
            PH_TAP:    tap = in_valid;
            default:   tap = 1'b0;
        endcase
    end

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator #(
    parameter int W     = 12,
    parameter int L     = 4,
    parameter int D     = 6,
    parameter int ORDER = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    logic               tap;
    logic signed [W-1:0] x_scaled;
    logic [W-1:0]       integ_chain [0:ORDER];
    logic [W-1:0]       comb_chain  [0:ORDER];

    // Pre-scale: arithmetic shift, sign bits fill the top.
    assign x_scaled       = $signed(in_data) >>> D;
    assign integ_chain[0] = x_scaled;
    assign comb_chain[0]  = integ_chain[ORDER];

    cic_decim_ctrl #(.L(L)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .tap      (tap)
    );

    for (genvar i = 0; i < ORDER; i++) begin : g_integ
        cic_integ_stage #(.W(W)) u_integ (
            .clk     (clk),
            .rst     (rst),
            .en      (in_valid),
            .din     (integ_chain[i]),
            .sum_nxt (integ_chain[i+1])
        );
    end

    for (genvar i = 0; i < ORDER; i++) begin : g_comb
        cic_comb_stage #(.W(W)) u_comb (
            .clk  (clk),
            .rst  (rst),
            .en   (tap),
            .din  (comb_chain[i]),
            .dout (comb_chain[i+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= tap;
            if (tap) begin
                out_data <= comb_chain[ORDER];
            end
        end
    end

endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
    parameter int W = 12,
    parameter int L = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic         out_valid,
    input logic [W-1:0] out_data
);

    localparam int CW = $clog2(L) + 1;

    logic [CW-1:0] seen_q;

    // Independent count of accepted samples within a group.
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (in_valid) begin
            seen_q <= (seen_q == CW'(L - 1)) ? '0 : seen_q + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    group_end_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) && $past(seen_q) == CW'(L - 1)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R3
    no_missed_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seen_q == CW'(L - 1)) |=> out_valid);

    logic unused_in;
    assign unused_in = ^in_data;

endmodule

bind cic_decimator cic_decimator_chk #(.W(W), .L(L)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/cic_decimator_bench.sv
module cic_decimator_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 12;
    localparam int L    = 4;
    localparam int D    = 6;
    localparam int NH   = 3 * L - 2;
    localparam int HMAX = 16384;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int h  [0:NH-1];
    int xs [0:HMAX-1];
    int n_acc = 0;
    int last_out = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cic_decimator #(.W(W), .L(L), .D(D)) u_cic_decimator (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int wrapw(longint v);
        logic [W-1:0] t;
        t = v[W-1:0];
        return int'($signed(t));
    endfunction

    function automatic int sext(int v);
        logic [W-1:0] t;
        t = v[W-1:0];
        return int'($signed(t));
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R5 reference: threefold boxcar convolution
    task automatic build_taps();
        int a [0:NH-1];
        int b [0:NH-1];
        for (int i = 0; i < NH; i++) a[i] = (i < L) ? 1 : 0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < NH; i++) begin
                b[i] = 0;
                for (int k = 0; k < L; k++)
                    if (i - k >= 0) b[i] += a[i-k];
            end
            for (int i = 0; i < NH; i++) a[i] = b[i];
        end
        for (int i = 0; i < NH; i++) h[i] = a[i];
    endtask

    function automatic int expected_at(int n);
        longint s = 0;
        for (int j = 0; j < NH; j++)
            if (n - j >= 0) s += longint'(h[j]) * xs[n-j];
        return wrapw(s);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", sext(int'(out_data)), 0);
        rst = 1'b0;
        n_acc = 0;
        last_out = 0;
        pulses = 0;
    endtask

    // One cycle: drive at negedge, sample at following negedge.
    task automatic push(bit v, int d);
        bit exp_pulse;
        in_valid = v;
        in_data  = d[W-1:0];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        exp_pulse = 1'b0;
        if (v) begin
            xs[n_acc] = sext(d) >>> D;   // R2 floor shift
            n_acc++;
            exp_pulse = (n_acc % L) == 0;
        end
        if (int'(out_valid) != int'(exp_pulse)) begin
            check("R3 pulse timing", int'(out_valid), int'(exp_pulse));
        end else if (exp_pulse) begin
            n_checks++;
            pulses++;
            check("R5 decimated value", sext(int'(out_data)), expected_at(n_acc - 1));
            last_out = sext(int'(out_data));
        end else begin
            check("R7 hold", sext(int'(out_data)), last_out);
        end
    endtask

    task automatic constant_run(int c, int cnt, string req);
        for (int i = 0; i < cnt; i++) push(1'b1, c);
        // R8 steady-state gain
        check(req, last_out, L * L * L * (sext(c) >>> D));
    endtask

    initial begin
        build_taps();
        do_reset();

        // R6 full-scale positive, sums wrap many times
        constant_run(2047, 2000, "R6 R8 positive full scale");
        do_reset();
        constant_run(-2048, 2000, "R6 R8 negative full scale");
        // R2 shift rounding corners
        do_reset();
        constant_run(-1, 40, "R2 minus one");
        do_reset();
        constant_run(63, 40, "R2 just below step");
        do_reset();
        constant_run(64, 40, "R2 one step");

        // R4 exhaustive code sweep with idle cycles
        do_reset();
        for (int v = 0; v < (1 << W); v++) begin
            push(1'b1, v);
            if (v % 3 == 0) push(1'b0, 1234);
            if (v % 7 == 0) push(1'b0, -77);
        end

        // R5 pseudo-random stream
        do_reset();
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                push(lfsr[0] | lfsr[5], int'(lfsr[15:4]));
            end
        end

        // R1 reset part-way through a group restarts phase and history
        do_reset();
        push(1'b1, 1500);
        push(1'b1, -900);
        do_reset();
        for (int i = 0; i < 40; i++) push(1'b1, (i * 37) % 2048 - 1024);
        check("R1 phase restart pulse count", pulses, 40 / L);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule